// File: doc/BRIEF.md
# Vector condition-result bit packer

This unit walks a vector of `vl` elements over a file of 4-bit condition fields. For each element it reads one field, compares the field's bits against a 4-bit pattern under a 4-bit mask, and reduces the per-bit hits to a single result bit. The result bits are gathered into integer register values and written out through a register-file write port. The source can step through consecutive fields or reuse one field for every element. The destination can step through consecutive integer registers, packing 1, 2, 4 or 8 results into each, or it can stay on a single register that collects one bit per element.

A one-cycle `start` in the idle state latches all operands. The unit then handles one element per clock. It holds the bits for the current destination register in a local accumulator and issues exactly one write for each register, either when that register's group is full or when the last element is done. `busy` covers the whole operation, including the final write. A single-cycle `done` follows it. A `vl` of 0 is treated as 1.

Top module: `cond_bit_packer`

## Requirements
- R1: For field bits f[k] with k from 0 to 3, hit[k] = cmp_mask[k] & (cmp_mode[k] == f[k]). The element result is the OR of the four hits when red_or=1, and their AND when red_or=0. With red_or=0, any cleared mask bit therefore forces the result to 0.
- R2: With src_vec=1, element i reads field (src_base + i) modulo the field count (64 by default).
- R3: With src_vec=0, every element reads field src_base.
- R4: With dst_vec=1 and pack_ew=00, element i is written to bit 0 of register dst_base+i. All other bits of that register are 0.
- R5: With dst_vec=1 and pack_ew=01, element i goes to bit i%2 of register dst_base+i/2. Bits above bit 1 are 0.
- R6: With dst_vec=1 and pack_ew=10, element i goes to bit i%4 of register dst_base+i/4, with bits above bit 3 at 0. With pack_ew=11, it goes to bit i%8 of register dst_base+i/8, with bits above bit 7 at 0.
- R7: With dst_vec=0, element i goes to bit i of register dst_base, regardless of pack_ew. Exactly one write is made, after the last element, and bits at and above vl are 0.
- R8: A partly filled final group is still written when the last element completes, with its unused bits at 0. Destination register numbers wrap modulo the register count (32 by default).
- R9: busy rises in the cycle after start is sampled, and wr_en is only ever high while busy is high. The last write occurs vl cycles after start is sampled. busy falls one cycle later, and done is then high for exactly one cycle, so done appears vl+1 cycles after start.
- R10: A start that arrives while busy is high is ignored. The running operation's writes and timing are unchanged.
- R11: During reset and right after it, busy, done and wr_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| vl | input | 7 | Element count, 1 to 64 |
| red_or | input | 1 | 1: OR reduction, 0: AND reduction |
| cmp_mask | input | 4 | Per-bit compare enable |
| cmp_mode | input | 4 | Per-bit compare value |
| src_base | input | 6 | First (or only) condition field index |
| src_vec | input | 1 | 1: step through fields, 0: reuse one field |
| dst_base | input | 5 | First (or only) integer register index |
| dst_vec | input | 1 | 1: step through registers, 0: single register |
| pack_ew | input | 2 | Results per register: 00=1, 01=2, 10=4, 11=8 |
| fld_addr | output | 6 | Condition field read index |
| fld_data | input | 4 | Condition field contents (same-cycle read) |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 5 | Register write index |
| wr_data | output | 64 | Register write value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench exercises every packing density, including groups left partly filled by the last element. A design that skipped the flush of a partial group would lose those results, and one that forgot to clear the accumulator would leak bits from the previous group into the next register. It runs vectors that wrap both the field index and the register index: a design without modulo arithmetic would read or write the wrong entries. It covers AND reduction with a partial mask, which must always give 0, and a single-register destination with a non-zero width code, where a design that honoured the code would split the bits over several writes. It also sends a start while the unit is busy, which a careless design would use to restart or corrupt the running operation.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } cbp_state_e;

  // Index of the last bit in a packing group for a width code.
  function automatic int unsigned grp_last(input logic [1:0] ew);
    return (32'd1 << ew) - 32'd1;
  endfunction
endpackage

// File: rtl/cbp_reduce.sv
module cbp_reduce #(
  parameter int FBITS = 4
) (
  input  logic [FBITS-1:0] fld,
  input  logic [FBITS-1:0] mask,
  input  logic [FBITS-1:0] mode,
  input  logic             use_or,
  output logic             bit_o
);
  logic [FBITS-1:0] hit;

  for (genvar k = 0; k < FBITS; k++) begin : g_hit
    assign hit[k] = mask[k] & ~(mode[k] ^ fld[k]);
  end

  assign bit_o = use_or ? (|hit) : (&hit);
endmodule

// File: rtl/cbp_seq.sv
module cbp_seq
  import cbp_pkg::*;
#(
  parameter int VLW    = 7,
  parameter int IDXW   = 6,
  parameter int FIDX_W = 6,
  parameter int RIDX_W = 5,
  parameter int POSW   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [VLW-1:0]    vl_q,
  input  logic [FIDX_W-1:0] src_base_q,
  input  logic              src_vec_q,
  input  logic [RIDX_W-1:0] dst_base_q,
  input  logic              dst_vec_q,
  input  logic [1:0]        ew_q,
  output logic              idle,
  output logic              busy,
  output logic              done,
  output logic              step,
  output logic              flush,
  output logic [POSW-1:0]   pos,
  output logic [FIDX_W-1:0] fld_addr,
  output logic [RIDX_W-1:0] reg_addr
);
  cbp_state_e        state_q, state_d;
  logic [IDXW-1:0]   idx_q, idx_d;
  logic [POSW-1:0]   pos_q, pos_d;
  logic [RIDX_W-1:0] roff_q, roff_d;
  logic              done_q, done_d;
  logic              last, grp_full, ctr_en;

  always_comb begin
    idle     = (state_q == ST_IDLE);
    busy     = !idle;
    step     = (state_q == ST_RUN);
    last     = (VLW'(idx_q) + VLW'(1)) == vl_q;
    grp_full = dst_vec_q && (pos_q == POSW'(grp_last(ew_q)));
    flush    = step && (last || grp_full);
    fld_addr = src_base_q + (src_vec_q ? FIDX_W'(idx_q) : FIDX_W'(0));
    reg_addr = dst_base_q + roff_q;
    pos      = pos_q;
    done     = done_q;
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    pos_d   = pos_q;
    roff_d  = roff_q;
    done_d  = 1'b0;
    ctr_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (load) begin
          state_d = ST_RUN;
          idx_d   = '0;
          pos_d   = '0;
          roff_d  = '0;
          ctr_en  = 1'b1;
        end
      end
      ST_RUN: begin
        ctr_en  = 1'b1;
        idx_d   = idx_q + IDXW'(1);
        pos_d   = flush ? '0 : pos_q + POSW'(1);
        roff_d  = roff_q + RIDX_W'(flush);
        if (last) state_d = ST_FLUSH;
      end
      ST_FLUSH: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      pos_q  <= '0;
      roff_q <= '0;
    end else if (ctr_en) begin
      idx_q  <= idx_d;
      pos_q  <= pos_d;
      roff_q <= roff_d;
    end
  end
endmodule

// File: rtl/cbp_pack.sv
module cbp_pack #(
  parameter int XLEN   = 64,
  parameter int POSW   = 6,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              flush,
  input  logic              bit_i,
  input  logic [POSW-1:0]   pos,
  input  logic [RIDX_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [RIDX_W-1:0] wr_addr,
  output logic [XLEN-1:0]   wr_data
);
  logic [XLEN-1:0]   acc_q, acc_d, placed;
  logic              wr_en_q;
  logic [RIDX_W-1:0] wr_addr_q;
  logic [XLEN-1:0]   wr_data_q;

  always_comb begin
    placed = acc_q | (XLEN'(bit_i) << pos);
    acc_d  = flush ? '0 : placed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (step) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_en_q <= 1'b0;
    else        wr_en_q <= flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (flush) begin
      wr_addr_q <= reg_addr;
      wr_data_q <= placed;
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
endmodule

// File: rtl/cond_bit_packer.sv
module cond_bit_packer #(
  parameter  int XLEN    = 64,
  parameter  int VL_MAX  = 64,
  parameter  int NFIELDS = 64,
  parameter  int NREGS   = 32,
  localparam int FBITS   = 4,
  localparam int VLW     = $clog2(VL_MAX + 1),
  localparam int FIDX_W  = $clog2(NFIELDS),
  localparam int RIDX_W  = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VLW-1:0]    vl,
  input  logic              red_or,
  input  logic [FBITS-1:0]  cmp_mask,
  input  logic [FBITS-1:0]  cmp_mode,
  input  logic [FIDX_W-1:0] src_base,
  input  logic              src_vec,
  input  logic [RIDX_W-1:0] dst_base,
  input  logic              dst_vec,
  input  logic [1:0]        pack_ew,
  output logic [FIDX_W-1:0] fld_addr,
  input  logic [FBITS-1:0]  fld_data,
  output logic              wr_en,
  output logic [RIDX_W-1:0] wr_addr,
  output logic [XLEN-1:0]   wr_data,
  output logic              busy,
  output logic              done
);
  localparam int IDXW = $clog2(VL_MAX);
  localparam int POSW = $clog2(XLEN);

  logic              idle, load, step, flush, res_bit;
  logic [POSW-1:0]   pos;
  logic [RIDX_W-1:0] reg_addr;

  logic [VLW-1:0]    vl_q;
  logic              red_or_q, src_vec_q, dst_vec_q;
  logic [FBITS-1:0]  mask_q, mode_q;
  logic [FIDX_W-1:0] src_base_q;
  logic [RIDX_W-1:0] dst_base_q;
  logic [1:0]        ew_q;

  assign load = start && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q       <= VLW'(1);
      red_or_q   <= 1'b0;
      mask_q     <= '0;
      mode_q     <= '0;
      src_base_q <= '0;
      src_vec_q  <= 1'b0;
      dst_base_q <= '0;
      dst_vec_q  <= 1'b0;
      ew_q       <= '0;
    end else if (load) begin
      vl_q       <= (vl == '0) ? VLW'(1) : vl;
      red_or_q   <= red_or;
      mask_q     <= cmp_mask;
      mode_q     <= cmp_mode;
      src_base_q <= src_base;
      src_vec_q  <= src_vec;
      dst_base_q <= dst_base;
      dst_vec_q  <= dst_vec;
      ew_q       <= pack_ew;
    end
  end

  cbp_seq #(
    .VLW(VLW), .IDXW(IDXW), .FIDX_W(FIDX_W), .RIDX_W(RIDX_W), .POSW(POSW)
  ) u_seq (
    .clk, .rst_n, .load,
    .vl_q, .src_base_q, .src_vec_q, .dst_base_q, .dst_vec_q, .ew_q,
    .idle, .busy, .done, .step, .flush, .pos,
    .fld_addr, .reg_addr
  );

  cbp_reduce #(.FBITS(FBITS)) u_red (
    .fld(fld_data), .mask(mask_q), .mode(mode_q), .use_or(red_or_q),
    .bit_o(res_bit)
  );

  cbp_pack #(.XLEN(XLEN), .POSW(POSW), .RIDX_W(RIDX_W)) u_pack (
    .clk, .rst_n, .step, .flush, .bit_i(res_bit), .pos, .reg_addr,
    .wr_en, .wr_addr, .wr_data
  );
endmodule

module cbp_checker #(
  parameter int XLEN   = 64,
  parameter int VLW    = 7,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              wr_en,
  input logic [RIDX_W-1:0] wr_addr,
  input logic [XLEN-1:0]   wr_data,
  input logic              dst_vec_q,
  input logic [RIDX_W-1:0] dst_base_q,
  input logic [1:0]        ew_q,
  input logic [VLW-1:0]    vl_q
);
  p_wr_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  p_busy_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_scalar_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !dst_vec_q) |-> (wr_addr == dst_base_q));

  p_scalar_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !dst_vec_q) |=> !wr_en);

  // Covers R4 and R6 as well: no bit above the packing group is set.
  p_pack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dst_vec_q) |-> ((wr_data >> (32'd1 << ew_q)) == '0));

  p_hold_ops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(vl_q) && $stable(dst_base_q) && $stable(ew_q)));

  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r11: assert (!wr_en && !busy && !done);
    end
  end
endmodule

bind cond_bit_packer cbp_checker #(
  .XLEN(XLEN), .VLW(VLW), .RIDX_W(RIDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .dst_vec_q(dst_vec_q), .dst_base_q(dst_base_q), .ew_q(ew_q), .vl_q(vl_q)
);

// File: tb/cond_bit_packer_tb_top.sv
`timescale 1ns/1ps
module cond_bit_packer_tb_top;
  logic        clk, rst_n, start;
  logic [6:0]  vl;
  logic        red_or, src_vec, dst_vec;
  logic [3:0]  cmp_mask, cmp_mode, fld_data;
  logic [5:0]  src_base, fld_addr;
  logic [4:0]  dst_base, wr_addr;
  logic [1:0]  pack_ew;
  logic        wr_en, busy, done;
  logic [63:0] wr_data;

  logic [3:0]  fields [64];
  logic [4:0]  q_addr [$];
  logic [63:0] q_data [$];
  int          n_chk = 0;
  int          n_fail = 0;
  string       cur_req = "R11";
  bit          finished = 0;

  cond_bit_packer dut_i (
    .clk, .rst_n, .start, .vl, .red_or, .cmp_mask, .cmp_mode,
    .src_base, .src_vec, .dst_base, .dst_vec, .pack_ew,
    .fld_addr, .fld_data, .wr_en, .wr_addr, .wr_data, .busy, .done
  );

  assign fld_data = fields[fld_addr];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Monitor: pops one expected write per observed write.
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (q_addr.size() == 0) begin
        chk(cur_req, {59'd0, wr_addr}, 64'h0, "unexpected write (queue empty)");
      end else begin
        chk(cur_req, {59'd0, wr_addr}, {59'd0, q_addr.pop_front()}, "write address");
        chk(cur_req, wr_data, q_data.pop_front(), "write data");
      end
    end
  end

  task automatic fill(int seed);
    for (int i = 0; i < 64; i++) fields[i] = 4'((i * seed) + (i / 3) + seed);
  endtask

  function automatic logic elem(int i, logic s_vec, int s_base, logic [3:0] msk,
                                logic [3:0] mod, logic use_or);
    logic [3:0] f, h;
    f = fields[s_vec ? (s_base + i) % 64 : s_base];
    for (int k = 0; k < 4; k++) h[k] = msk[k] && (mod[k] == f[k]);
    return use_or ? (h != 0) : (h == 4'hF);
  endfunction

  task automatic run_op(string req, int n, logic use_or, logic [3:0] msk, logic [3:0] mod,
                        int s_base, logic s_vec, int d_base, logic d_vec,
                        logic [1:0] ew, bit interfere);
    int lat;
    cur_req = req;
    if (!d_vec) begin
      logic [63:0] d;
      d = '0;
      for (int i = 0; i < n; i++) d[i] = elem(i, s_vec, s_base, msk, mod, use_or);
      q_addr.push_back(5'(d_base));
      q_data.push_back(d);
    end else begin
      int per;
      per = 1 << ew;
      for (int g = 0; g * per < n; g++) begin
        logic [63:0] d;
        d = '0;
        for (int j = 0; j < per && g * per + j < n; j++)
          d[j] = elem(g * per + j, s_vec, s_base, msk, mod, use_or);
        q_addr.push_back(5'((d_base + g) % 32));
        q_data.push_back(d);
      end
    end
    @(negedge clk);
    start = 1'b1; vl = 7'(n); red_or = use_or; cmp_mask = msk; cmp_mode = mod;
    src_base = 6'(s_base); src_vec = s_vec; dst_base = 5'(d_base); dst_vec = d_vec;
    pack_ew = ew;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    chk("R9", {63'd0, busy}, 64'd1, "busy after start");
    while (!done) begin
      @(negedge clk);
      lat++;
      if (interfere && lat == 2) begin
        start = 1'b1; vl = 7'd3; dst_base = 5'd9; pack_ew = 2'b00; dst_vec = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    chk(interfere ? "R10" : "R9", 64'(lat), 64'(n + 1), "cycles start to done");
    chk(req, 64'(q_addr.size()), 64'd0, "pending writes after done");
    q_addr.delete();
    q_data.delete();
    @(negedge clk);
    chk("R9", {63'd0, done}, 64'd0, "done is a single pulse");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; vl = 7'd1; red_or = 1'b0; cmp_mask = '0; cmp_mode = '0;
    src_base = '0; src_vec = 1'b0; dst_base = '0; dst_vec = 1'b0; pack_ew = '0;
    fill(5);
    repeat (3) @(negedge clk);
    chk("R11", {61'd0, busy, done, wr_en}, 64'd0, "outputs held in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", {61'd0, busy, done, wr_en}, 64'd0, "outputs after reset");

    // R1 R2 R4: OR reduction, one result per register
    run_op("R4", 5, 1'b1, 4'b0110, 4'b0010, 2, 1'b1, 4, 1'b1, 2'b00, 0);
    // R1: AND reduction with full mask
    run_op("R1", 16, 1'b0, 4'b1111, 4'b1010, 0, 1'b1, 0, 1'b1, 2'b00, 0);
    // R1: AND reduction with partial mask gives all zero
    run_op("R1", 4, 1'b0, 4'b0111, 4'b0000, 7, 1'b1, 20, 1'b1, 2'b00, 0);
    // R5 R8: two per register, odd length leaves a partial group
    run_op("R5", 7, 1'b1, 4'b1001, 4'b1000, 3, 1'b1, 10, 1'b1, 2'b01, 0);
    fill(11);
    // R6 R8: four per register, partial last group
    run_op("R6", 10, 1'b1, 4'b0011, 4'b0001, 12, 1'b1, 1, 1'b1, 2'b10, 0);
    // R6 R8: eight per register, full length, register index wraps
    run_op("R8", 64, 1'b1, 4'b1100, 4'b0100, 0, 1'b1, 30, 1'b1, 2'b11, 0);
    // R3: scalar source field reused
    run_op("R3", 8, 1'b1, 4'b0101, 4'b0001, 17, 1'b0, 5, 1'b1, 2'b11, 0);
    fill(3);
    // R7: scalar destination, full length
    run_op("R7", 64, 1'b1, 4'b1110, 4'b0110, 0, 1'b1, 12, 1'b0, 2'b00, 0);
    // R7: scalar destination ignores the width code
    run_op("R7", 13, 1'b1, 4'b0011, 4'b0010, 5, 1'b1, 31, 1'b0, 2'b01, 0);
    // R2: field index wraps past the end of the file
    run_op("R2", 10, 1'b1, 4'b1111, 4'b0000, 60, 1'b1, 2, 1'b1, 2'b00, 0);
    // R10: start during busy is ignored
    run_op("R10", 9, 1'b1, 4'b1010, 4'b1010, 40, 1'b1, 16, 1'b1, 2'b01, 1);
    repeat (4) @(negedge clk);
    chk("R10", {62'd0, busy, wr_en}, 64'd0, "no second operation after ignored start");
    summary();
  end
endmodule